// File: doc/BRIEF.md
# Burst Frame Strobe Generator

This block handles the two frame markers that travel beside a sample stream. On the receive side it turns a data-valid qualifier into an outgoing frame strobe. In level style the strobe is high for the whole valid run. In pulse style it toggles with equal high and low halves for as long as samples are valid. On the transmit side it watches the frame strobe that the baseband processor sends. It raises a one-cycle start-of-burst pulse on the first rising edge of a burst, holds a busy flag while the burst lasts, and raises a one-cycle end-of-burst pulse once the incoming strobe has been quiet for longer than a whole frame period.

The frame period is a parameter counted in sample clocks and must be even. The incoming strobe may use either style, and the detector needs no mode input to accept both. All outputs are registered. The receive strobe therefore lags the valid qualifier by exactly one clock, which matches a registered sample path.

Top module: `burst_frame_strobe`

## Requirements
- R1: While reset is asserted and on the first clock after it, rx_frame_o, tx_sob_o, tx_eob_o and tx_busy_o are all 0.
- R2: rx_frame_o is 0 in every cycle that follows a clock edge at which rx_valid_i was 0.
- R3: With rx_pulse_mode_i = 0 (level style), rx_frame_o is 1 in every cycle that follows an edge at which rx_valid_i was 1.
- R4: With rx_pulse_mode_i = 1 (pulse style), the k-th consecutive valid sample of a run (k counted from 0) produces rx_frame_o = 1 when (k mod FRAME_PERIOD) < FRAME_PERIOD/2, and 0 otherwise, one clock later.
- R5: In pulse style, a valid run that starts after any cycle with rx_valid_i = 0 (even a single one) restarts the pattern in its high half.
- R6: When the detector is idle, a sample with tx_frame_i = 1 that follows a sample with tx_frame_i = 0 gives tx_sob_o = 1 for exactly one cycle, in the clock after that sample, and sets tx_busy_o in the same cycle. After reset, the previous sample counts as 0.
- R7: While tx_busy_o is 1, further rising edges on tx_frame_i do not raise tx_sob_o, in either style of incoming strobe.
- R8: A busy burst ends when tx_frame_i is 0 for FRAME_PERIOD+1 consecutive samples. tx_eob_o is 1 for one cycle in the clock after the last of them, and a low run of FRAME_PERIOD samples or fewer does not end the burst.
- R9: tx_busy_o is 1 from the cycle of tx_sob_o up to the cycle before tx_eob_o, and is 0 from the cycle of tx_eob_o on.
- R10: tx_sob_o and tx_eob_o are never 1 in the same cycle, and tx_eob_o is 1 only in the cycle after one in which tx_busy_o was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Receive samples are valid this cycle |
| rx_pulse_mode_i | input | 1 | Receive strobe style: 0 level, 1 pulse |
| rx_frame_o | output | 1 | Outgoing receive frame strobe |
| tx_frame_i | input | 1 | Incoming transmit frame strobe |
| tx_sob_o | output | 1 | One-cycle start-of-burst indication |
| tx_eob_o | output | 1 | One-cycle end-of-burst indication |
| tx_busy_o | output | 1 | An incoming burst is in progress |

## Verification
Receive valid runs are drawn at random, both shorter and longer than a frame period, in either style, with gaps as short as one cycle. This separates a phase counter that restarts per run from one that runs freely or merely pauses. The transmit strobe is driven as level bursts, as pulse-style toggling bursts and as isolated short glitches, with idle gaps on both sides of the end threshold. Directed cases place a gap of exactly FRAME_PERIOD and of FRAME_PERIOD+1 low samples, so an off-by-one in the end detector shows up, and they send repeated rising edges inside one burst to show that only the first one starts it.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
    typedef enum logic {
        STYLE_LEVEL = 1'b0,
        STYLE_PULSE = 1'b1
    } frame_style_e;
endpackage

// File: rtl/bfs_rx_strobe.sv
module bfs_rx_strobe
    import bfs_pkg::*;
#(
    parameter int PERIOD = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  frame_style_e style_i,
    output logic         frame_o
);
    localparam int HALF = PERIOD / 2;
    localparam int PW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    typedef struct packed {
        logic          frame;
        logic [PW-1:0] phase;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!valid_i) begin
            st_d.frame = 1'b0;
            st_d.phase = '0;
        end else if (style_i == STYLE_LEVEL) begin
            st_d.frame = 1'b1;
            st_d.phase = '0;
        end else begin
            st_d.frame = (st_q.phase < PW'(HALF));
            st_d.phase = (st_q.phase == PW'(PERIOD - 1)) ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_o = st_q.frame;

    // R2
    frame_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_i) |-> !frame_o);

    // R3
    level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && $past(style_i) == STYLE_LEVEL) |-> frame_o);

    // R5
    pulse_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(valid_i) && style_i == STYLE_PULSE) |=> frame_o);
endmodule

// File: rtl/bfs_tx_detect.sv
module bfs_tx_detect #(
    parameter int PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_i,
    output logic sob_o,
    output logic eob_o,
    output logic busy_o
);
    localparam int LW = $clog2(PERIOD + 1);

    typedef struct packed {
        logic          prev;
        logic          busy;
        logic          sob;
        logic          eob;
        logic [LW-1:0] low;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      rising;

    always_comb begin
        rising   = frame_i && !st_q.prev;
        st_d     = st_q;
        st_d.prev = frame_i;
        st_d.sob = 1'b0;
        st_d.eob = 1'b0;
        if (!st_q.busy) begin
            st_d.low = '0;
            if (rising) begin
                st_d.sob  = 1'b1;
                st_d.busy = 1'b1;
            end
        end else if (frame_i) begin
            st_d.low = '0;
        end else if (st_q.low == LW'(PERIOD)) begin
            st_d.eob  = 1'b1;
            st_d.busy = 1'b0;
            st_d.low  = '0;
        end else begin
            st_d.low = st_q.low + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sob_o  = st_q.sob;
    assign eob_o  = st_q.eob;
    assign busy_o = st_q.busy;

    // R6
    sob_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sob_o |-> busy_o);

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !sob_o);

    // R8
    eob_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eob_o |-> ($past(busy_o) && !$past(frame_i) && !busy_o));

    // R10
    sob_eob_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sob_o && eob_o));
endmodule

// File: rtl/burst_frame_strobe.sv
module burst_frame_strobe
    import bfs_pkg::*;
#(
    parameter int FRAME_PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid_i,
    input  logic rx_pulse_mode_i,
    output logic rx_frame_o,
    input  logic tx_frame_i,
    output logic tx_sob_o,
    output logic tx_eob_o,
    output logic tx_busy_o
);
    frame_style_e rx_style;
    assign rx_style = frame_style_e'(rx_pulse_mode_i);

    bfs_rx_strobe #(.PERIOD(FRAME_PERIOD)) rx_gen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (rx_valid_i),
        .style_i (rx_style),
        .frame_o (rx_frame_o)
    );

    bfs_tx_detect #(.PERIOD(FRAME_PERIOD)) tx_det_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (tx_frame_i),
        .sob_o   (tx_sob_o),
        .eob_o   (tx_eob_o),
        .busy_o  (tx_busy_o)
    );

    // R9
    busy_ends_with_eob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(tx_busy_o)) |-> tx_eob_o);
endmodule

// File: tb/burst_frame_strobe_tb.sv
module burst_frame_strobe_tb_top;
    localparam int P    = 8;
    localparam int HALF = P / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic rx_pm = 1'b0;
    logic tx_frame = 1'b0;
    logic rx_frame_o, tx_sob_o, tx_eob_o, tx_busy_o;

    int checks = 0;
    int errors = 0;

    // reference state
    int   m_idx = 0;
    logic m_lastv = 1'b0;
    logic m_prev = 1'b0;
    logic m_busy = 1'b0;
    int   m_low = 0;
    string rx_tag_force = "";

    always #2 clk = ~clk;

    burst_frame_strobe #(.FRAME_PERIOD(P)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .rx_valid_i      (rx_valid),
        .rx_pulse_mode_i (rx_pm),
        .rx_frame_o      (rx_frame_o),
        .tx_frame_i      (tx_frame),
        .tx_sob_o        (tx_sob_o),
        .tx_eob_o        (tx_eob_o),
        .tx_busy_o       (tx_busy_o)
    );

    function automatic logic exp_rx_frame(input logic v, input logic pm, input int idx);
        if (!v) return 1'b0;
        if (!pm) return 1'b1;
        return ((idx % P) < HALF);
    endfunction

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic pm, input logic tf);
        logic  e_frame, e_sob, e_eob, was_busy;
        string ftag;
        @(negedge clk);
        rx_valid = v;
        rx_pm    = pm;
        tx_frame = tf;
        m_idx    = v ? (m_lastv ? m_idx + 1 : 0) : 0;
        m_lastv  = v;
        e_frame  = exp_rx_frame(v, pm, m_idx);
        ftag     = !v ? "R2" : (pm ? "R4" : "R3");
        if (rx_tag_force != "") ftag = rx_tag_force;
        e_sob    = 1'b0;
        e_eob    = 1'b0;
        was_busy = m_busy;
        if (!m_busy) begin
            m_low = 0;
            if (tf && !m_prev) begin
                e_sob  = 1'b1;
                m_busy = 1'b1;
            end
        end else if (tf) begin
            m_low = 0;
        end else if (m_low == P) begin
            e_eob  = 1'b1;
            m_busy = 1'b0;
            m_low  = 0;
        end else begin
            m_low++;
        end
        m_prev = tf;
        @(posedge clk);
        #1;
        check_bit(rx_frame_o, e_frame, ftag);
        check_bit(tx_sob_o, e_sob, was_busy ? "R7" : "R6");
        check_bit(tx_eob_o, e_eob, "R8");
        check_bit(tx_busy_o, m_busy, "R9");
        check_bit(tx_sob_o && tx_eob_o, 1'b0, "R10");
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rx_left;
        int tx_left;
        int tx_kind;
        int tx_pos;
        logic tx_active;
        logic rv;
        logic rpm;
        logic tf;
        void'($urandom(32'h5eed_0b17));

        // R1: outputs during reset
        rx_valid = 1'b1;
        tx_frame = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check_bit(rx_frame_o, 1'b0, "R1");
        check_bit(tx_sob_o,   1'b0, "R1");
        check_bit(tx_eob_o,   1'b0, "R1");
        check_bit(tx_busy_o,  1'b0, "R1");
        @(negedge clk);
        rx_valid = 1'b0;
        tx_frame = 1'b0;
        rst_n    = 1'b1;
        @(posedge clk);
        #1;
        check_bit(rx_frame_o, 1'b0, "R1");
        check_bit(tx_busy_o,  1'b0, "R1");
        m_prev = 1'b0;

        // R5: pulse run, one-cycle gap, new run restarts high
        rx_tag_force = "R5";
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        rx_tag_force = "";

        // R8: gap of exactly P low samples keeps the burst, P+1 ends it
        step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < P; i++) step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < P + 1; i++) step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);

        // R7: pulse-style incoming strobe gives one start only
        for (int i = 0; i < 5 * P; i++) step(1'b1, 1'b0, ((i % P) < HALF));
        for (int i = 0; i < P + 3; i++) step(1'b0, 1'b0, 1'b0);

        // R6: single-cycle glitch starts a burst
        step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < P + 2; i++) step(1'b0, 1'b0, 1'b0);

        // random mix
        rx_left   = 0;
        tx_left   = 0;
        tx_kind   = 0;
        tx_pos    = 0;
        tx_active = 1'b0;
        rv        = 1'b0;
        rpm       = 1'b0;
        for (int n = 0; n < 6000; n++) begin
            if (rx_left == 0) begin
                if (rv) begin
                    rv = 1'b0;
                    rx_left = $urandom_range(1, 5);
                end else begin
                    rv = 1'b1;
                    rpm = $urandom_range(0, 1) == 1;
                    rx_left = $urandom_range(1, 3 * P);
                end
            end
            rx_left--;
            if (tx_left == 0) begin
                tx_active = !tx_active;
                tx_pos = 0;
                if (tx_active) begin
                    tx_kind = $urandom_range(0, 2);
                    tx_left = (tx_kind == 2) ? $urandom_range(1, 2) : $urandom_range(1, 4 * P);
                end else begin
                    tx_left = $urandom_range(1, 2 * P + 3);
                end
            end
            if (!tx_active)       tf = 1'b0;
            else if (tx_kind == 1) tf = ((tx_pos % P) < HALF);
            else                  tf = 1'b1;
            tx_pos++;
            tx_left--;
            step(rv, rpm, tf);
        end
        for (int i = 0; i < P + 3; i++) step(1'b0, rpm, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule